// File: doc/BRIEF.md
# Bus Trace Capture Buffer

This block records bus-cycle samples into an on-chip trace RAM. Each sample is kept only when the CPU cycle strobe and the per-cycle release from the trigger sequencer are both high while tracing is enabled. Every stored record holds three parts: the sample word, the value of a free-running 48-bit timestamp at the moment of capture, and three marker bits from the sequencer. The trace sequencer starts and stops tracing with on and off commands. A full flag goes back to it as a trigger input.

The depth is set at run time through a depth input and clamped to a legal window. Two fill policies are available. The wrap policy keeps the most recent window of records and overwrites the oldest. The stop policy keeps the earliest window and ignores releases once that window is full. A synchronous clear empties the buffer but leaves the timestamp and the tracing state alone. Readback takes a logical index counted from the oldest valid record and returns that record one clock later.

Top module: `trace_capture`

## Requirements
- R1: While reset is asserted, full_o, wr_ptr_o, rec_cnt_o and tracing_o are all zero.
- R2: A cycle is stored only when cyc_vld_i and cyc_rel_i are both high and tracing_o is high. trc_on_i and trc_off_i change tracing_o at the next clock edge. When both are high in the same cycle, off wins.
- R3: A stored record holds sample_i, the timestamp value present before the capturing edge, and mark_i as bits {C,B,A} = mark_i[2:0].
- R4: The 48-bit timestamp starts at zero at reset and advances by one at each edge where ts_tick_i is high. clr_i does not reset it.
- R5: With fill_mode_i = 0 (wrap), storing continues after the buffer is full and overwrites the oldest record. wr_ptr_o equals the number of stores since the last clear, modulo the effective depth. rec_cnt_o saturates at the effective depth.
- R6: With fill_mode_i = 1 (stop), releases are ignored once the buffer is full. full_o, rec_cnt_o and the stored contents stay unchanged, and wr_ptr_o stays at 0.
- R7: The effective depth is depth_i clamped to the range MIN_DEPTH (4) to 2^ADDR_W (64).
- R8: full_o rises at the same edge that writes the record that brings the count up to the effective depth, and it stays high until a clear.
- R9: When clr_i is high, wr_ptr_o, rec_cnt_o and full_o are zero after the next edge, and no record is stored in that cycle. tracing_o and the timestamp keep their values.
- R10: The read outputs show the record at logical position rd_idx_i one clock after rd_idx_i is applied. Index 0 is the oldest valid record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to clk |
| clr_i | input | 1 | Synchronous clear of the pointer, count and full flag |
| fill_mode_i | input | 1 | 0 = wrap (keep newest), 1 = stop (keep oldest) |
| depth_i | input | ADDR_W+1 | Requested trace depth, clamped |
| trc_on_i | input | 1 | Start tracing |
| trc_off_i | input | 1 | Stop tracing, wins over start |
| cyc_vld_i | input | 1 | CPU cycle strobe |
| cyc_rel_i | input | 1 | Per-cycle trace release |
| mark_i | input | 3 | Marker bits {C,B,A} |
| sample_i | input | SAMPLE_W | Bus sample word |
| ts_tick_i | input | 1 | Timestamp advance enable |
| rd_idx_i | input | ADDR_W | Logical read index from the oldest record |
| full_o | output | 1 | Buffer holds the effective depth of records |
| wr_ptr_o | output | ADDR_W | Next physical write slot |
| rec_cnt_o | output | ADDR_W+1 | Number of valid records |
| tracing_o | output | 1 | Tracing enabled |
| rd_sample_o | output | SAMPLE_W | Read record: sample |
| rd_ts_o | output | TS_W | Read record: timestamp |
| rd_mark_o | output | 3 | Read record: markers |

## Verification
The bench drives a wrap-mode buffer past full and then reads it back. The record at index 0 must be the oldest surviving record. A design that indexes physically from slot 0 returns the newest records out of order. In stop mode the bench releases more records than fit. A design that does not stop moves the pointer and overwrites the early window. The bench also checks the clamp at both ends with requests below the minimum and above the array size. It raises clear and release together, and trace on and off together, where a wrong priority stores a record or leaves tracing enabled. It holds the timestamp tick low across two stores. A counter that runs freely, or one that the clear resets, shows up in the stored timestamps.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int MARK_W = 3;

  typedef enum logic {
    FILL_WRAP = 1'b0,
    FILL_STOP = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/trace_tstamp.sv
module trace_tstamp #(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  output logic [TS_W-1:0] ts_o
);
  logic [TS_W-1:0] ts_q, ts_nx;

  always_comb begin
    ts_nx = ts_q;
    if (tick_i) ts_nx = ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_nx;
  end

  assign ts_o = ts_q;
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int MIN_DEPTH = 4,
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic              on_i,
  input  logic              off_i,
  input  logic              vld_i,
  input  logic              rel_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o,
  output logic              armed_o,
  output logic [CNT_W-1:0]  eff_o,
  output logic [ADDR_W-1:0] oldest_o
);
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(1 << ADDR_W);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DEPTH);

  logic [CNT_W-1:0]  eff;
  logic              armed_q, armed_nx;
  logic [ADDR_W-1:0] ptr_q, ptr_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic              full_q, full_nx;
  logic              fire, at_last;

  // depth clamp
  always_comb begin
    if (depth_i < FLOOR)     eff = FLOOR;
    else if (depth_i > CAP)  eff = CAP;
    else                     eff = depth_i;
  end

  always_comb begin
    fire    = vld_i & rel_i & armed_q & ~clr_i &
              ((mode_i == FILL_WRAP) | ~full_q);
    at_last = ({1'b0, ptr_q} >= (eff - 1'b1));

    armed_nx = armed_q;
    if (off_i)     armed_nx = 1'b0;
    else if (on_i) armed_nx = 1'b1;

    ptr_nx = ptr_q;
    cnt_nx = cnt_q;
    if (clr_i) begin
      ptr_nx = '0;
      cnt_nx = '0;
    end else if (fire) begin
      ptr_nx = at_last ? '0 : ptr_q + 1'b1;
      if (cnt_q < eff) cnt_nx = cnt_q + 1'b1;
    end

    if (clr_i) full_nx = 1'b0;
    else       full_nx = full_q | (fire & (cnt_nx >= eff));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      armed_q <= armed_nx;
      ptr_q   <= ptr_nx;
      cnt_q   <= cnt_nx;
      full_q  <= full_nx;
    end
  end

  assign we_o     = fire;
  assign ptr_o    = ptr_q;
  assign cnt_o    = cnt_q;
  assign full_o   = full_q;
  assign armed_o  = armed_q;
  assign eff_o    = eff;
  assign oldest_o = ((mode_i == FILL_WRAP) && full_q) ? ptr_q : '0;
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int ADDR_W = 6,
  parameter int REC_W  = 83,
  localparam int SLOTS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [REC_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [REC_W-1:0]  rdata_o
);
  logic [REC_W-1:0] mem [SLOTS];
  logic [REC_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rd_q <= mem[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_pkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int TS_W      = 48,
  parameter int ADDR_W    = 6,
  parameter int MIN_DEPTH = 4,
  localparam int CNT_W    = ADDR_W + 1,
  localparam int REC_W    = MARK_W + TS_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                fill_mode_i,
  input  logic [CNT_W-1:0]    depth_i,
  input  logic                trc_on_i,
  input  logic                trc_off_i,
  input  logic                cyc_vld_i,
  input  logic                cyc_rel_i,
  input  logic [MARK_W-1:0]   mark_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                ts_tick_i,
  input  logic [ADDR_W-1:0]   rd_idx_i,
  output logic                full_o,
  output logic [ADDR_W-1:0]   wr_ptr_o,
  output logic [CNT_W-1:0]    rec_cnt_o,
  output logic                tracing_o,
  output logic [SAMPLE_W-1:0] rd_sample_o,
  output logic [TS_W-1:0]     rd_ts_o,
  output logic [MARK_W-1:0]   rd_mark_o
);
  logic [TS_W-1:0]   ts_cur;
  logic              we;
  logic [ADDR_W-1:0] ptr, oldest, raddr;
  logic [CNT_W-1:0]  eff, rsum;
  logic [REC_W-1:0]  wrec, rrec;

  trace_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .tick_i(ts_tick_i), .ts_o(ts_cur)
  );

  trace_ctrl #(.ADDR_W(ADDR_W), .MIN_DEPTH(MIN_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(fill_mode_i),
    .depth_i(depth_i), .on_i(trc_on_i), .off_i(trc_off_i),
    .vld_i(cyc_vld_i), .rel_i(cyc_rel_i), .we_o(we), .ptr_o(ptr),
    .cnt_o(rec_cnt_o), .full_o(full_o), .armed_o(tracing_o),
    .eff_o(eff), .oldest_o(oldest)
  );

  // logical index -> physical slot, modulo the effective depth
  always_comb begin
    rsum = {1'b0, oldest} + {1'b0, rd_idx_i};
    if (rsum >= eff) rsum = rsum - eff;
    raddr = rsum[ADDR_W-1:0];
  end

  assign wrec = {mark_i, ts_cur, sample_i};

  trace_store #(.ADDR_W(ADDR_W), .REC_W(REC_W)) u_store (
    .clk(clk), .we_i(we), .waddr_i(ptr), .wdata_i(wrec),
    .raddr_i(raddr), .rdata_o(rrec)
  );

  assign wr_ptr_o    = ptr;
  assign rd_sample_o = rrec[SAMPLE_W-1:0];
  assign rd_ts_o     = rrec[SAMPLE_W +: TS_W];
  assign rd_mark_o   = rrec[REC_W-1 -: MARK_W];
endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int TS_W      = 48,
  parameter int ADDR_W    = 6,
  parameter int MIN_DEPTH = 4,
  localparam int CNT_W    = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              fill_mode_i,
  input logic              trc_off_i,
  input logic              cyc_vld_i,
  input logic              cyc_rel_i,
  input logic              ts_tick_i,
  input logic              full_o,
  input logic [ADDR_W-1:0] wr_ptr_o,
  input logic [CNT_W-1:0]  rec_cnt_o,
  input logic              tracing_o,
  input logic [TS_W-1:0]   ts_cur
);
  localparam logic [CNT_W-1:0] CAP   = CNT_W'(1 << ADDR_W);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DEPTH);

  p_no_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_vld_i && cyc_rel_i) && !clr_i |=> $stable(rec_cnt_o) && $stable(wr_ptr_o));

  p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trc_off_i |=> !tracing_o);

  p_ts_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ts_tick_i |=> ts_cur == $past(ts_cur) + 1'b1);

  p_ts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_tick_i |=> $stable(ts_cur));

  p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_o && !clr_i |=> full_o);

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_mode_i && full_o && !clr_i |=> $stable(rec_cnt_o) && $stable(wr_ptr_o));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> rec_cnt_o == '0 && wr_ptr_o == '0 && !full_o);

  p_cnt_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_cnt_o <= CAP && (!full_o || rec_cnt_o >= FLOOR));
endmodule

bind trace_capture trace_capture_chk #(
  .TS_W(TS_W), .ADDR_W(ADDR_W), .MIN_DEPTH(MIN_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fill_mode_i(fill_mode_i),
  .trc_off_i(trc_off_i), .cyc_vld_i(cyc_vld_i), .cyc_rel_i(cyc_rel_i),
  .ts_tick_i(ts_tick_i), .full_o(full_o), .wr_ptr_o(wr_ptr_o),
  .rec_cnt_o(rec_cnt_o), .tracing_o(tracing_o), .ts_cur(ts_cur)
);

// File: tb/trace_capture_bench.sv
module trace_capture_bench;
  localparam int AW = 6, SW = 32, TW = 48, MIND = 4, CW = AW + 1, CAPN = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, clr, mode, on, off, cv, rel, tick, rd_chk, pend;
  logic [CW-1:0] depth;
  logic [2:0]    mk;
  logic [SW-1:0] smp;
  logic [AW-1:0] ridx;
  logic          full, trc;
  logic [AW-1:0] wptr;
  logic [CW-1:0] cnt;
  logic [SW-1:0] rs;
  logic [TW-1:0] rt;
  logic [2:0]    rm;

  typedef struct packed {
    logic [2:0]    m;
    logic [TW-1:0] t;
    logic [SW-1:0] s;
  } rec_t;

  rec_t hist[$];
  rec_t sb[$];
  int n_chk = 0, n_bad = 0, stores = 0;
  bit armed_m = 1'b0;
  logic [TW-1:0] ts_m;

  trace_capture u_trace_capture (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .fill_mode_i(mode), .depth_i(depth),
    .trc_on_i(on), .trc_off_i(off), .cyc_vld_i(cv), .cyc_rel_i(rel),
    .mark_i(mk), .sample_i(smp), .ts_tick_i(tick), .rd_idx_i(ridx),
    .full_o(full), .wr_ptr_o(wptr), .rec_cnt_o(cnt), .tracing_o(trc),
    .rd_sample_o(rs), .rd_ts_o(rt), .rd_mark_o(rm)
  );

  // timestamp model from R4
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ts_m <= '0;
    else if (tick) ts_m <= ts_m + 1'b1;

  function automatic int eff();
    if (int'(depth) < MIND) return MIND;
    if (int'(depth) > CAPN) return CAPN;
    return int'(depth);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle_in();
    clr = 0; on = 0; off = 0; cv = 0; rel = 0; mk = '0; smp = '0; rd_chk = 0;
  endtask

  // driver: one cycle of stimulus, model updated for the coming edge
  task automatic step(bit v, bit r, bit o_n, bit o_f, bit c, logic [2:0] m, logic [SW-1:0] s);
    bit st;
    cv = v; rel = r; on = o_n; off = o_f; clr = c; mk = m; smp = s;
    st = v && r && armed_m && !c && (mode == 1'b0 || stores < eff());
    if (c) begin
      hist.delete();
      stores = 0;
    end else if (st) begin
      hist.push_back('{m: m, t: ts_m, s: s});
      if (hist.size() > eff()) void'(hist.pop_front());
      stores++;
    end
    if (o_f) armed_m = 1'b0;
    else if (o_n) armed_m = 1'b1;
    @(posedge clk); #1;
    idle_in();
  endtask

  task automatic status(string tag);
    int e;
    e = eff();
    @(negedge clk);
    chk({tag, " full"},    64'(full), 64'(stores >= e));
    chk({tag, " wr_ptr"},  64'(wptr), 64'(stores % e));
    chk({tag, " rec_cnt"}, 64'(cnt),  64'((stores < e) ? stores : e));
    chk({tag, " tracing"}, 64'(trc),  64'(armed_m));
    @(posedge clk); #1;
  endtask

  // driver side of the scoreboard: push expected record for this read
  task automatic rd(int i);
    ridx = AW'(i);
    rd_chk = 1'b1;
    sb.push_back(hist[i]);
    @(posedge clk); #1;
    rd_chk = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin : mon
    rec_t e;
    if (pend === 1'b1) begin
      e = sb.pop_front();
      chk("R10 sample", 64'(rs), 64'(e.s));
      chk("R3 timestamp", 64'(rt), 64'(e.t));
      chk("R3 marks", 64'(rm), 64'(e.m));
    end
    pend <= rd_chk;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pend = 1'b0; idle_in();
    mode = 1'b0; depth = CW'(8); tick = 1'b1; ridx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 full", 64'(full), 0);
    chk("R1 wr_ptr", 64'(wptr), 0);
    chk("R1 rec_cnt", 64'(cnt), 0);
    chk("R1 tracing", 64'(trc), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: release before tracing, then tracing takes effect one cycle later
    step(1, 1, 0, 0, 0, 3'b001, 32'hDEAD0000);
    status("R2 untraced");
    step(1, 1, 1, 0, 0, 3'b010, 32'hDEAD0001);
    status("R2 on-delay");

    // R2/R3: mixed qualifiers, wrap mode depth 8
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 0, 0, 0, 3'b111, 32'hBAD0 + i);
      step(0, 1, 0, 0, 0, 3'b111, 32'hBAD8 + i);
      step(1, 1, 0, 0, 0, 3'(i), 32'hA000 + i);
    end
    status("R2 five");
    for (int i = 0; i < 5; i++) rd(i);

    // R4: two stores with the tick held low
    tick = 1'b0;
    step(1, 1, 0, 0, 0, 3'b101, 32'hB000);
    step(1, 1, 0, 0, 0, 3'b110, 32'hB001);
    tick = 1'b1;

    // R5/R8: go past full in wrap mode, status after each store
    for (int i = 0; i < 5; i++) begin
      step(1, 1, 0, 0, 0, 3'(i + 3), 32'hC000 + i);
      status("R8 R5 wrap");
    end
    for (int i = 0; i < 8; i++) rd(i);

    // R9: clear wins over a release
    step(1, 1, 0, 0, 1, 3'b001, 32'hE000);
    status("R9 clear");
    step(1, 1, 0, 0, 0, 3'b011, 32'hE001);
    rd(0);

    // R2: on and off together, off wins; releases then ignored
    step(1, 1, 0, 0, 1, 3'b000, 32'h0);
    step(0, 0, 1, 1, 0, 3'b000, 32'h0);
    status("R2 off-wins");
    step(1, 1, 0, 0, 0, 3'b100, 32'hF000);
    status("R2 off");

    // R6/R7: stop mode, depth request 2 clamps to 4
    mode = 1'b1; depth = CW'(2);
    step(0, 0, 1, 0, 0, 3'b000, 32'h0);
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 0, 0, 0, 3'(7 - i), 32'h5000 + i);
      status("R6 R7 stop");
    end
    for (int i = 0; i < 4; i++) rd(i);

    // R7/R5: request above the array clamps to 64, wrap past full
    step(0, 0, 0, 0, 1, 3'b000, 32'h0);
    mode = 1'b0; depth = CW'(100);
    for (int i = 0; i < 70; i++) step(1, 1, 0, 0, 0, 3'(i), 32'h7000 + i);
    status("R7 R5 big");
    rd(0); rd(1); rd(63);

    repeat (4) @(posedge clk);
    chk("R10 scoreboard drained", 64'(sb.size()), 0);
    finish_run();
  end
endmodule